// File: doc/BRIEF.md
# Load/Store Effective Address Sequencer

This block turns a data-movement instruction into memory traffic for a 16-bit, word-addressed machine. On a start pulse it captures the instruction word, the program counter already advanced past that instruction, the value of the base register the instruction names, and the value of the register the instruction stores from. It then forms the effective address in one of three ways and runs the memory accesses that the instruction needs:

- **PC-relative:** the advanced PC plus a 9-bit signed offset.
- **Base+offset:** the base register plus a 6-bit signed offset.
- **Indirect:** a PC-relative read whose returned word becomes the final address.

The memory side is a single-port request interface. The sequencer holds an address, a write enable and write data steady until the memory raises a ready signal.

When a load finishes, or when the instruction only computes an address, the block gives the value for the destination register. It gives it with a one-cycle register-write strobe and a matching condition-code update strobe. A store gives only a completion pulse. The register file, the ALU and instruction fetch sit outside the block. The surrounding core reads the two source registers and presents them with the start pulse.

Top module: `ldst_ea_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `mem_req`, `mem_we`, `op_done`, `rf_we` and `cc_we` are all low.
- R2: For the direct PC-relative load (opcode 0010) and store (opcode 0011), the memory address equals `pc_next` plus the sign-extended bits [8:0] of the instruction, taken modulo 2^16. This gives a reach from -256 to +255 words around `pc_next`.
- R3: For the base+offset load (opcode 0110) and store (opcode 0111), the memory address equals `base_val` plus the sign-extended bits [5:0] of the instruction, taken modulo 2^16.
- R4: For the indirect load (opcode 1010) and store (opcode 1011), the block first reads at the PC-relative address of R2. It then performs the load or store at the word returned by that read.
- R5: The address-compute instruction (opcode 1110) makes no memory request. It writes the PC-relative address of R2 to the destination register.
- R6: A store drives `mem_we` high and `mem_wdata` equal to `src_val` on its final access. It never raises `rf_we`.
- R7: A load raises `rf_we` and `cc_we` for exactly one cycle, after its last access completes. The write carries `rf_waddr` equal to instruction bits [11:9] and `rf_wdata` equal to the word read by that access.
- R8: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` do not change, and the request stays up.
- R9: The timing of each operation is fixed. The cycle after an accepted start is an address cycle with no request. Each access lasts until the first cycle in which `mem_ready` is high. The completion cycle (`op_done` high) follows directly, and the block is idle in the next cycle.
- R10: A start pulse during `busy` has no effect. Changes to `instr`, `pc_next`, `base_val` and `src_val` after the accepted start do not alter the running operation.
- R11: A start with any other opcode (for example 0000, 0001, 1100 or 1111) is not accepted: `busy` stays low and no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Offer an instruction to the sequencer |
| instr | input | 16 | Instruction word |
| pc_next | input | 16 | Program counter already advanced past the instruction |
| base_val | input | 16 | Value of the register named by instruction bits [8:6] |
| src_val | input | 16 | Value of the register named by instruction bits [11:9] |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the current access this cycle |
| busy | output | 1 | An operation is in progress |
| op_done | output | 1 | Completion pulse |
| rf_we | output | 1 | Destination register write strobe |
| rf_waddr | output | 3 | Destination register index |
| rf_wdata | output | 16 | Destination register value |
| cc_we | output | 1 | Condition-code update strobe |

## Verification
The assertions assume the memory answers every request within finite time. They also assume the memory model keeps `mem_ready` low whenever `mem_req` is low, so that an access completes only while the request is up. The stimulus assumes `start` is only meaningful while the block is idle.

The bench plays the memory itself. It raises `mem_ready` only during request cycles, after a chosen number of wait cycles, and it drives read data from its own word map. In some operations it deliberately keeps `start` high and changes the operands while the block is busy, to test that those inputs are ignored.

// File: rtl/ldst_pkg.sv
// Package: shared types of the load/store address sequencer.
// Assumes a 4-bit major opcode in the top bits of the instruction word.
package ldst_pkg;

    // Major opcodes of the data-movement instructions handled here.
    localparam logic [3:0] OPC_LD  = 4'b0010;
    localparam logic [3:0] OPC_ST  = 4'b0011;
    localparam logic [3:0] OPC_LDR = 4'b0110;
    localparam logic [3:0] OPC_STR = 4'b0111;
    localparam logic [3:0] OPC_LDI = 4'b1010;
    localparam logic [3:0] OPC_STI = 4'b1011;
    localparam logic [3:0] OPC_LEA = 4'b1110;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ADDR,
        SQ_PTR,
        SQ_XFER,
        SQ_DONE
    } seq_state_t;

    typedef struct packed {
        logic valid;      // opcode is one of the handled instructions
        logic is_load;    // result comes from memory
        logic is_store;   // final access writes memory
        logic is_lea;     // result is the address itself
        logic indirect;   // pointer read precedes the final access
        logic base_mode;  // address from base register, not PC
    } op_class_t;

endpackage

// File: rtl/ldst_decode.sv
// Module: ldst_decode
// Classifies a major opcode into the operation flags used by the
// sequencer. Purely combinational; unknown opcodes give valid = 0.
module ldst_decode
    import ldst_pkg::*;
(
    input  logic [3:0] opcode,
    output op_class_t  cls
);

    // Map each handled opcode onto its flag set.
    always_comb begin
        cls = '0;
        unique case (opcode)
            OPC_LD:  begin cls.valid = 1'b1; cls.is_load  = 1'b1; end
            OPC_ST:  begin cls.valid = 1'b1; cls.is_store = 1'b1; end
            OPC_LDR: begin cls.valid = 1'b1; cls.is_load  = 1'b1; cls.base_mode = 1'b1; end
            OPC_STR: begin cls.valid = 1'b1; cls.is_store = 1'b1; cls.base_mode = 1'b1; end
            OPC_LDI: begin cls.valid = 1'b1; cls.is_load  = 1'b1; cls.indirect  = 1'b1; end
            OPC_STI: begin cls.valid = 1'b1; cls.is_store = 1'b1; cls.indirect  = 1'b1; end
            OPC_LEA: begin cls.valid = 1'b1; cls.is_lea   = 1'b1; end
            default: cls = '0;
        endcase
    end

endmodule

// File: rtl/ldst_ea_calc.sv
// Module: ldst_ea_calc
// Forms the effective address: advanced PC plus a sign-extended long
// offset, or base register plus a sign-extended short offset. The short
// offset is the low BASE_OFF_W bits of the long offset field.
// Assumes BASE_OFF_W <= PC_OFF_W < WORD_W. Sums wrap modulo 2^WORD_W.
module ldst_ea_calc #(
    parameter int WORD_W     = 16,
    parameter int PC_OFF_W   = 9,
    parameter int BASE_OFF_W = 6
) (
    input  logic                base_mode,
    input  logic [WORD_W-1:0]   pc_val,
    input  logic [WORD_W-1:0]   base_val,
    input  logic [PC_OFF_W-1:0] off_field,
    output logic [WORD_W-1:0]   ea
);

    localparam int PC_PAD   = WORD_W - PC_OFF_W;
    localparam int BASE_PAD = WORD_W - BASE_OFF_W;

    logic [WORD_W-1:0] pc_off_sx;
    logic [WORD_W-1:0] base_off_sx;

    // Sign-extend both offset forms to the word width.
    always_comb begin
        pc_off_sx   = {{PC_PAD{off_field[PC_OFF_W-1]}}, off_field};
        base_off_sx = {{BASE_PAD{off_field[BASE_OFF_W-1]}}, off_field[BASE_OFF_W-1:0]};
    end

    // Select the addressing mode and add.
    always_comb begin
        if (base_mode)
            ea = base_val + base_off_sx;
        else
            ea = pc_val + pc_off_sx;
    end

endmodule

// File: rtl/ldst_seq.sv
// Module: ldst_seq
// Control and datapath registers of the sequencer. Captures operands on
// an accepted start, latches the effective address, runs the optional
// pointer read and the final access, then issues one completion cycle.
// Assumes mem_ready is only meaningful while mem_req is high.
module ldst_seq
    import ldst_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int PC_OFF_W  = 9,
    parameter int REG_SEL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  op_class_t            cls_in,
    input  logic [REG_SEL_W+PC_OFF_W-1:0] fields_in,
    input  logic [WORD_W-1:0]    pc_in,
    input  logic [WORD_W-1:0]    base_in,
    input  logic [WORD_W-1:0]    src_in,
    input  logic [WORD_W-1:0]    ea,
    output logic                 base_mode_q,
    output logic [PC_OFF_W-1:0]  off_q,
    output logic [WORD_W-1:0]    pc_q,
    output logic [WORD_W-1:0]    base_q,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [WORD_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic [WORD_W-1:0]    mem_rdata,
    input  logic                 mem_ready,
    output logic                 busy,
    output logic                 op_done,
    output logic                 rf_we,
    output logic [REG_SEL_W-1:0] rf_waddr,
    output logic [WORD_W-1:0]    rf_wdata,
    output logic                 cc_we
);

    seq_state_t           state;
    op_class_t            cls_q;
    logic [REG_SEL_W-1:0] dst_q;
    logic [WORD_W-1:0]    src_q;
    logic [WORD_W-1:0]    addr_q;
    logic [WORD_W-1:0]    data_q;

    assign base_mode_q = cls_q.base_mode;

    // State transitions and operand/address/data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            cls_q  <= '0;
            dst_q  <= '0;
            off_q  <= '0;
            pc_q   <= '0;
            base_q <= '0;
            src_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (start && cls_in.valid) begin
                        cls_q  <= cls_in;
                        dst_q  <= fields_in[REG_SEL_W+PC_OFF_W-1:PC_OFF_W];
                        off_q  <= fields_in[PC_OFF_W-1:0];
                        pc_q   <= pc_in;
                        base_q <= base_in;
                        src_q  <= src_in;
                        state  <= SQ_ADDR;
                    end
                end
                SQ_ADDR: begin
                    addr_q <= ea;
                    if (cls_q.is_lea)
                        state <= SQ_DONE;
                    else if (cls_q.indirect)
                        state <= SQ_PTR;
                    else
                        state <= SQ_XFER;
                end
                SQ_PTR: begin
                    if (mem_ready) begin
                        addr_q <= mem_rdata;
                        state  <= SQ_XFER;
                    end
                end
                SQ_XFER: begin
                    if (mem_ready) begin
                        if (cls_q.is_load)
                            data_q <= mem_rdata;
                        state <= SQ_DONE;
                    end
                end
                SQ_DONE: state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Memory interface drive, held constant for the whole access.
    always_comb begin
        mem_req   = (state == SQ_PTR) || (state == SQ_XFER);
        mem_we    = (state == SQ_XFER) && cls_q.is_store;
        mem_addr  = addr_q;
        mem_wdata = mem_we ? src_q : '0;
    end

    // Completion and register write-back strobes.
    always_comb begin
        busy     = (state != SQ_IDLE);
        op_done  = (state == SQ_DONE);
        rf_we    = op_done && (cls_q.is_load || cls_q.is_lea);
        cc_we    = rf_we;
        rf_waddr = dst_q;
        rf_wdata = cls_q.is_lea ? addr_q : data_q;
    end

    // R1: an idle sequencer neither requests memory nor writes back.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !rf_we && !cc_we));

    // R4: the word returned by the pointer read becomes the access address.
    assert_ptr_becomes_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_PTR && mem_ready) |=> (mem_req && mem_addr == $past(mem_rdata)));

    // R5: the address-compute instruction never reaches memory.
    assert_lea_no_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cls_q.is_lea) |-> !mem_req);

    // R6: a write access is never paired with a register write.
    assert_store_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !rf_we);

    // R7: write-back is a single-cycle pulse that ends the operation.
    assert_wb_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> (!rf_we && !busy));

    // R8: a pending access keeps its address, direction and data.
    assert_hold_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                     && $stable(mem_we) && $stable(mem_wdata)));

endmodule

// File: rtl/ldst_ea_seq.sv
// Module: ldst_ea_seq (top)
// Effective address sequencer for the data-movement instructions of a
// word-addressed machine. Decodes the opcode at start, hands captured
// operands to the address adder and runs the memory sequence.
// Assumes base_val/src_val are the registers named by the instruction.
module ldst_ea_seq
    import ldst_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int PC_OFF_W   = 9,
    parameter int BASE_OFF_W = 6,
    parameter int REG_SEL_W  = 3,
    parameter int OPC_W      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [OPC_W+REG_SEL_W+PC_OFF_W-1:0] instr,
    input  logic [WORD_W-1:0]    pc_next,
    input  logic [WORD_W-1:0]    base_val,
    input  logic [WORD_W-1:0]    src_val,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [WORD_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic [WORD_W-1:0]    mem_rdata,
    input  logic                 mem_ready,
    output logic                 busy,
    output logic                 op_done,
    output logic                 rf_we,
    output logic [REG_SEL_W-1:0] rf_waddr,
    output logic [WORD_W-1:0]    rf_wdata,
    output logic                 cc_we
);

    localparam int INSTR_W = OPC_W + REG_SEL_W + PC_OFF_W;
    localparam int FIELD_W = REG_SEL_W + PC_OFF_W;

    op_class_t           cls_in;
    logic                base_mode_q;
    logic [PC_OFF_W-1:0] off_q;
    logic [WORD_W-1:0]   pc_q;
    logic [WORD_W-1:0]   base_q;
    logic [WORD_W-1:0]   ea;

    ldst_decode u_decode (
        .opcode (instr[INSTR_W-1:FIELD_W]),
        .cls    (cls_in)
    );

    ldst_ea_calc #(
        .WORD_W     (WORD_W),
        .PC_OFF_W   (PC_OFF_W),
        .BASE_OFF_W (BASE_OFF_W)
    ) u_calc (
        .base_mode (base_mode_q),
        .pc_val    (pc_q),
        .base_val  (base_q),
        .off_field (off_q),
        .ea        (ea)
    );

    ldst_seq #(
        .WORD_W    (WORD_W),
        .PC_OFF_W  (PC_OFF_W),
        .REG_SEL_W (REG_SEL_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cls_in      (cls_in),
        .fields_in   (instr[FIELD_W-1:0]),
        .pc_in       (pc_next),
        .base_in     (base_val),
        .src_in      (src_val),
        .ea          (ea),
        .base_mode_q (base_mode_q),
        .off_q       (off_q),
        .pc_q        (pc_q),
        .base_q      (base_q),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_ready   (mem_ready),
        .busy        (busy),
        .op_done     (op_done),
        .rf_we       (rf_we),
        .rf_waddr    (rf_waddr),
        .rf_wdata    (rf_wdata),
        .cc_we       (cc_we)
    );

endmodule

// File: tb/ldst_ea_seq_tb.sv
// Bench: ldst_ea_seq_tb
// Plays the memory and the issuing core. For every operation it derives
// the expected per-cycle port values from the requirements and compares
// them at each falling edge.
module ldst_ea_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] pc_next = '0;
    logic [15:0] base_val = '0;
    logic [15:0] src_val = '0;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        mem_req, mem_we, busy, op_done, rf_we, cc_we;
    logic [15:0] mem_addr, mem_wdata, rf_wdata;
    logic [2:0]  rf_waddr;

    int vectors = 0;
    int misses  = 0;
    logic [15:0] wmem [logic [15:0]];

    always #5 clk = ~clk;

    ldst_ea_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .pc_next(pc_next), .base_val(base_val), .src_val(src_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .busy(busy), .op_done(op_done), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .cc_we(cc_we)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] rd_word(input logic [15:0] a);
        return wmem.exists(a) ? wmem[a] : 16'h0000;
    endfunction

    // Compare the strobes every cycle; addresses and data only where defined.
    task automatic cmp_cycle(input string req, input bit e_busy, input bit e_req,
                             input bit e_we, input logic [15:0] e_addr,
                             input logic [15:0] e_wdata, input bit e_done,
                             input bit e_rfwe, input logic [15:0] e_rfdata,
                             input logic [2:0] e_rfaddr);
        chk(busy == e_busy, req, "busy", 16'(busy), 16'(e_busy));
        chk(mem_req == e_req, req, "mem_req", 16'(mem_req), 16'(e_req));
        chk(mem_we == e_we, req, "mem_we", 16'(mem_we), 16'(e_we));
        chk(op_done == e_done, req, "op_done", 16'(op_done), 16'(e_done));
        chk(rf_we == e_rfwe, req, "rf_we", 16'(rf_we), 16'(e_rfwe));
        chk(cc_we == e_rfwe, req, "cc_we", 16'(cc_we), 16'(e_rfwe));
        if (e_req) chk(mem_addr == e_addr, req, "mem_addr", mem_addr, e_addr);
        if (e_we)  chk(mem_wdata == e_wdata, req, "mem_wdata", mem_wdata, e_wdata);
        if (e_rfwe) begin
            chk(rf_wdata == e_rfdata, req, "rf_wdata", rf_wdata, e_rfdata);
            chk(rf_waddr == e_rfaddr, req, "rf_waddr", 16'(rf_waddr), 16'(e_rfaddr));
        end
    endtask

    // One memory access with lat wait cycles; R8 covers the waiting cycles.
    task automatic access(input string req, input logic [15:0] a, input bit we,
                          input logic [15:0] wd, input int lat, input bit junk,
                          output logic [15:0] rd);
        rd = rd_word(a);
        for (int k = 0; k <= lat; k++) begin
            @(negedge clk);
            mem_ready = (k == lat);
            mem_rdata = (k == lat) ? rd : 16'hDEAD;
            if (junk) begin
                start = 1'b1; instr = 16'h2E01 ^ 16'(k); base_val = ~base_val; src_val = src_val + 16'h0101;
            end
            cmp_cycle(k == 0 ? req : "R8", 1'b1, 1'b1, we, a, wd, 1'b0, 1'b0, '0, '0);
            @(posedge clk);
        end
        if (we) wmem[a] = wd;
    endtask

    task automatic run_op(input logic [15:0] ins, input logic [15:0] pc,
                          input logic [15:0] bv, input logic [15:0] sv,
                          input int lat, input bit junk, input string req);
        logic [3:0]  op = ins[15:12];
        bit is_ld  = (op == 4'b0010 || op == 4'b0110 || op == 4'b1010);
        bit is_st  = (op == 4'b0011 || op == 4'b0111 || op == 4'b1011);
        bit is_lea = (op == 4'b1110);
        bit ind    = (op == 4'b1010 || op == 4'b1011);
        bit bmode  = (op == 4'b0110 || op == 4'b0111);
        logic [15:0] ea, tgt, rd;
        ea = bmode ? bv + {{10{ins[5]}}, ins[5:0]} : pc + {{7{ins[8]}}, ins[8:0]};
        rd = '0;
        @(negedge clk);
        mem_ready = 1'b0;
        start = 1'b1; instr = ins; pc_next = pc; base_val = bv; src_val = sv;
        cmp_cycle("R9", 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);
        @(posedge clk);
        @(negedge clk);
        if (junk) begin
            instr = 16'h6FFF; pc_next = ~pc; base_val = ~bv; src_val = ~sv;  // R10
        end else start = 1'b0;
        cmp_cycle("R9", 1'b1, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);
        @(posedge clk);
        tgt = ea;
        if (ind) access("R4", ea, 1'b0, '0, lat, junk, tgt);
        if (!is_lea) access(req, tgt, is_st, sv, lat, junk, rd);
        @(negedge clk);
        mem_ready = 1'b0;
        cmp_cycle(is_lea ? "R5" : (is_ld ? "R7" : "R6"), 1'b1, 1'b0, 1'b0, '0, '0, 1'b1,
                  is_ld || is_lea, is_lea ? ea : rd, ins[11:9]);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cmp_cycle(junk ? "R10" : "R9", 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);
    endtask

    // A rejected opcode must leave the block idle with no request.
    task automatic reject(input logic [15:0] ins);
        @(negedge clk);
        start = 1'b1; instr = ins;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cmp_cycle("R11", 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);
        @(posedge clk);
        @(negedge clk);
        cmp_cycle("R11", 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp_cycle("R1", 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);
        rst_n = 1'b1;

        wmem[16'h30FF] = 16'h1111;
        wmem[16'hFF05] = 16'h8002;
        wmem[16'h3FE0] = 16'h7E7E;
        wmem[16'h401F] = 16'h0BAD;
        wmem[16'h2010] = 16'h1234;
        wmem[16'h1234] = 16'hBEEF;
        wmem[16'h2020] = 16'h5555;

        // R5: address compute, offset -3 from the advanced PC x30F7.
        run_op(16'hE3FD, 16'h30F7, 16'h0, 16'h0, 0, 1'b0, "R5");
        // R2: direct load at the positive reach limit, no wait.
        run_op(16'h22FF, 16'h3000, 16'h0, 16'h0, 0, 1'b0, "R2");
        // R2: direct load at the negative limit, wrapping below zero.
        run_op(16'h2500, 16'h0005, 16'h0, 16'h0, 2, 1'b0, "R2");
        // R2 R6 R8: direct store, three wait cycles.
        run_op(16'h3A05, 16'h4000, 16'h0, 16'hA5C3, 3, 1'b0, "R2");
        run_op(16'h2005, 16'h4000, 16'h0, 16'h0, 0, 1'b0, "R2");
        // R3: base+offset load, offsets -32 and +31.
        run_op(16'h6620, 16'h0, 16'h4000, 16'h0, 1, 1'b0, "R3");
        run_op(16'h685F, 16'h0, 16'h4000, 16'h0, 0, 1'b0, "R3");
        // R3 R6: base+offset store wrapping past the top.
        run_op(16'h7E1F, 16'h0, 16'hFFF0, 16'h0F0F, 2, 1'b0, "R3");
        run_op(16'h601F, 16'h0, 16'hFFF0, 16'h0, 0, 1'b0, "R3");
        // R4: indirect load through a pointer.
        run_op(16'hA410, 16'h2000, 16'h0, 16'h0, 2, 1'b0, "R4");
        // R4 R6: indirect store, then direct readback of the target.
        wmem[16'h1234] = 16'h0000;
        run_op(16'hB610, 16'h2000, 16'h0, 16'hC0DE, 1, 1'b0, "R4");
        run_op(16'h6200, 16'h0, 16'h1234, 16'h0, 0, 1'b0, "R4");
        // R10: start and operands toggled while busy.
        run_op(16'hA810, 16'h2000, 16'h1111, 16'h2222, 2, 1'b1, "R10");
        run_op(16'h3C20, 16'h2000, 16'h3333, 16'h6789, 1, 1'b1, "R10");
        run_op(16'hEFFF, 16'h8000, 16'h0, 16'h0, 0, 1'b1, "R10");
        run_op(16'h2020, 16'h2000, 16'h0, 16'h0, 0, 1'b0, "R10");
        // R11: opcodes outside the handled set.
        reject(16'h0E05);
        reject(16'h1234);
        reject(16'hC1C0);
        reject(16'hF025);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule